// File: doc/BRIEF.md
# SPI Bus Sniffer Stream Encoder

This block listens to an SPI bus without driving it and turns what it sees into a byte stream for a host transmit path. Clock, both data lines and the active-low chip select are brought into the system clock domain through a synchroniser chain. They are then edge-detected and shifted into a MOSI byte and a MISO byte in parallel. The edge used for sampling follows a three-bit clock configuration.

The host starts a capture with one of three command bytes, and each one picks which chip-select level gates the capture. While capturing, the block wraps each chip-select window in bracket characters. Each completed byte pair goes out as a backslash followed by the MOSI byte and then the MISO byte. Encoded bytes wait in an internal FIFO until the transmit side accepts them.

While a capture runs, a host byte of `r` restarts it and any other host byte ends it. If an encoded item does not fit in the FIFO, the capture stops and the status output drops.

Top module: `spi_sniff_enc`

## Requirements
- R1: After reset, and whenever no capture is running, the block produces no stream bytes from bus activity, ignores host bytes other than 0x0D, 0x0E and 0x0F, and holds sniffActive low.
- R2: In the idle state, host byte 0x0D starts capture of all traffic, 0x0E starts capture gated by csn low, and 0x0F starts capture gated by csn high. sniffActive is high while a capture runs.
- R3: During capture, a chip-select enable edge emits 0x5B ('[') and a disable edge emits 0x5D (']'). The enable edge is a falling csn in the 0x0D and 0x0E modes and a rising csn in the 0x0F mode.
- R4: Every eight sample edges emit a record of three bytes: 0x5C ('\'), then the MOSI byte, then the MISO byte. Both bytes are assembled MSB first.
- R5: The 0x0E mode shifts bits only while csn is low and the 0x0F mode only while csn is high. The 0x0D mode shifts bits at every csn level.
- R6: cfgIdleHigh gives the idle level of the SPI clock. The leading edge is the idle-to-active transition. Bits are sampled on the leading edge when cfgShiftTrail XOR cfgSampleLate is 1, and on the trailing edge otherwise.
- R7: Any chip-select edge clears the bit count, so a byte that is only partly shifted is discarded without output.
- R8: A host byte of 0x72 ('r') during capture clears the bit count, emits nothing and keeps the capture running.
- R9: Any other host byte during capture ends it, emits 0x01 and drops sniffActive.
- R10: The FIFO holds 32 bytes. If a record or bracket needs more space than is free, none of it is written, capture stops and sniffActive drops. In that halted state, 0x72 resumes capture and any other host byte emits 0x01 and returns to idle.
- R11: Stream bytes leave in the order they were produced. While txValid is high and txReady is low, txValid and txData hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Monitored SPI clock |
| spiMosi | input | 1 | Monitored controller-to-target data |
| spiMiso | input | 1 | Monitored target-to-controller data |
| spiCsn | input | 1 | Monitored active-low chip select |
| cfgIdleHigh | input | 1 | SPI clock idle level |
| cfgShiftTrail | input | 1 | Bus data changes on the trailing edge |
| cfgSampleLate | input | 1 | Move sampling to the opposite edge |
| hostValid | input | 1 | Host byte strobe |
| hostByte | input | 8 | Host command byte |
| txReady | input | 1 | Transmit side accepts a byte |
| txValid | output | 1 | Stream byte available |
| txData | output | 8 | Stream byte |
| sniffActive | output | 1 | High while capture runs |

## Verification
The bench runs each capture mode against the same kinds of chip-select pattern. These include windows at the gating level, traffic at the opposite level, and traffic with no window at all, which tells a correct filter apart from a mode that brackets or records the wrong level. The SPI driver changes the data lines shortly after the edge that should not be sampled. As a result, each clock configuration yields the right byte only if the correct edge is used. Partial bytes are cut off by a chip-select edge and by a restart, and the FIFO is filled with the transmit side stalled, which shows where the abort lands and that the halted state recovers.

// File: rtl/spi_sniff_pkg.sv
package spi_sniff_pkg;

  localparam int BYTE_W   = 8;
  localparam int MAX_PUSH = 4;

  typedef enum logic [1:0] {
    FILT_ALL  = 2'd0,
    FILT_LOW  = 2'd1,
    FILT_HIGH = 2'd2
  } filt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNIFF = 2'd1,
    ST_HALT  = 2'd2
  } state_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clrShift;
    logic captureEn;
    logic pushOpen;
    logic pushClose;
    logic pushRecord;
    logic pushAck;
  } strobe_t;

  localparam logic [BYTE_W-1:0] CODE_OPEN    = 8'h5B;
  localparam logic [BYTE_W-1:0] CODE_CLOSE   = 8'h5D;
  localparam logic [BYTE_W-1:0] CODE_ESC     = 8'h5C;
  localparam logic [BYTE_W-1:0] CODE_ACK     = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_RESTART  = 8'h72;
  localparam logic [BYTE_W-1:0] CMD_ALL      = 8'h0D;
  localparam logic [BYTE_W-1:0] CMD_LOW      = 8'h0E;
  localparam logic [BYTE_W-1:0] CMD_HIGH     = 8'h0F;

endpackage

// File: rtl/sniff_data.sv
module sniff_data
  import spi_sniff_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclkIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              csnIn,
  input  logic              cfgIdleHigh,
  input  logic              cfgShiftTrail,
  input  logic              cfgSampleLate,
  input  strobe_t           strb,
  input  logic              txReady,
  output logic              csRise,
  output logic              csFall,
  output logic              csLevel,
  output logic              byteDone,
  output logic [CNT_W-1:0]  freeCnt,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData
);

  localparam int PIPE_W = SYNC_STAGES * 4;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [3:0] PIPE_RST = 4'b0001;

  // ---------------- synchroniser chain ----------------
  logic [PIPE_W-1:0] syncPipe;
  logic sclkS, mosiS, misoS, csnS;
  logic sclkPrev, csnPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncPipe <= {SYNC_STAGES{PIPE_RST}};
      sclkPrev <= 1'b0;
      csnPrev  <= 1'b1;
    end else begin
      syncPipe <= {syncPipe[PIPE_W-5:0], sclkIn, mosiIn, misoIn, csnIn};
      sclkPrev <= sclkS;
      csnPrev  <= csnS;
    end
  end

  assign {sclkS, mosiS, misoS, csnS} = syncPipe[PIPE_W-1 -: 4];

  // ---------------- edge detection ----------------
  logic sclkUp, sclkDown, leadEdge, trailEdge, sampleEdge;

  assign sclkUp     = ~sclkPrev & sclkS;
  assign sclkDown   = sclkPrev & ~sclkS;
  assign leadEdge   = cfgIdleHigh ? sclkDown : sclkUp;
  assign trailEdge  = cfgIdleHigh ? sclkUp : sclkDown;
  assign sampleEdge = (cfgShiftTrail ^ cfgSampleLate) ? leadEdge : trailEdge;

  assign csRise  = ~csnPrev & csnS;
  assign csFall  = csnPrev & ~csnS;
  assign csLevel = csnS;

  // ---------------- parallel shifters ----------------
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] mosiSh, misoSh, mosiHold, misoHold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      mosiSh   <= '0;
      misoSh   <= '0;
      mosiHold <= '0;
      misoHold <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strb.clrShift) begin
        bitCnt <= '0;
      end else if (strb.captureEn && sampleEdge) begin
        mosiSh <= {mosiSh[BYTE_W-2:0], mosiS};
        misoSh <= {misoSh[BYTE_W-2:0], misoS};
        if (bitCnt == BIT_W'(BYTE_W - 1)) begin
          bitCnt   <= '0;
          byteDone <= 1'b1;
          mosiHold <= {mosiSh[BYTE_W-2:0], mosiS};
          misoHold <= {misoSh[BYTE_W-2:0], misoS};
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // ---------------- multi-byte write staging ----------------
  logic [BYTE_W-1:0] wrSlot [MAX_PUSH];
  logic [2:0]        wrN;

  always_comb begin
    for (int i = 0; i < MAX_PUSH; i++) wrSlot[i] = '0;
    wrN = 3'd0;
    if (strb.pushRecord) begin
      wrSlot[0] = CODE_ESC;
      wrSlot[1] = mosiHold;
      wrSlot[2] = misoHold;
      wrN       = 3'd3;
    end
    if (strb.pushOpen || strb.pushClose) begin
      wrSlot[wrN[1:0]] = strb.pushOpen ? CODE_OPEN : CODE_CLOSE;
      wrN              = wrN + 3'd1;
    end
    if (strb.pushAck) begin
      wrSlot[0] = CODE_ACK;
      wrN       = 3'd1;
    end
  end

  // ---------------- stream FIFO ----------------
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              pop;

  assign txValid = (count != '0);
  assign txData  = mem[rdPtr];
  assign pop     = txValid & txReady;
  assign freeCnt = CNT_W'(DEPTH) - count;

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_PUSH; i++) begin
      if (3'(i) < wrN) mem[wrPtr + PTR_W'(i)] <= wrSlot[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(wrN);
      if (pop) rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(wrN) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/sniff_ctrl.sv
module sniff_ctrl
  import spi_sniff_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostValid,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic              csRise,
  input  logic              csFall,
  input  logic              csLevel,
  input  logic              byteDone,
  input  logic [CNT_W-1:0]  freeCnt,
  output strobe_t           strb,
  output state_e            state
);

  state_e stateNext;
  filt_e  filt, filtNext;
  logic   enEdge, disEdge, csActive, isStart, isRestart;
  logic [2:0] need;

  assign enEdge    = (filt == FILT_HIGH) ? csRise : csFall;
  assign disEdge   = (filt == FILT_HIGH) ? csFall : csRise;
  assign csActive  = (filt == FILT_HIGH) ? csLevel : ~csLevel;
  assign isStart   = (hostByte == CMD_ALL) || (hostByte == CMD_LOW) || (hostByte == CMD_HIGH);
  assign isRestart = (hostByte == CMD_RESTART);
  assign need      = (byteDone ? 3'd3 : 3'd0) + ((enEdge || disEdge) ? 3'd1 : 3'd0);

  always_comb begin
    strb      = '0;
    stateNext = state;
    filtNext  = filt;
    unique case (state)
      ST_IDLE: begin
        if (hostValid && isStart) begin
          stateNext     = ST_SNIFF;
          strb.clrShift = 1'b1;
          unique case (hostByte[1:0])
            2'b01:   filtNext = FILT_ALL;
            2'b10:   filtNext = FILT_LOW;
            default: filtNext = FILT_HIGH;
          endcase
        end
      end
      ST_SNIFF: begin
        strb.captureEn = (filt == FILT_ALL) || csActive;
        if (hostValid) begin
          if (isRestart) begin
            strb.clrShift = 1'b1;
          end else begin
            stateNext    = ST_IDLE;
            strb.pushAck = (freeCnt != '0);
          end
        end else if (int'(need) > int'(freeCnt)) begin
          stateNext      = ST_HALT;
          strb.captureEn = 1'b0;
        end else begin
          strb.pushRecord = byteDone;
          strb.pushOpen   = enEdge;
          strb.pushClose  = disEdge;
          strb.clrShift   = enEdge || disEdge;
        end
      end
      ST_HALT: begin
        if (hostValid) begin
          if (isRestart) begin
            stateNext     = ST_SNIFF;
            strb.clrShift = 1'b1;
          end else begin
            stateNext    = ST_IDLE;
            strb.pushAck = (freeCnt != '0);
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      filt  <= FILT_ALL;
    end else begin
      state <= stateNext;
      filt  <= filtNext;
    end
  end

endmodule

// File: rtl/spi_sniff_enc.sv
module spi_sniff_enc
  import spi_sniff_pkg::*;
#(
  parameter int FIFO_DEPTH  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiSclk,
  input  logic              spiMosi,
  input  logic              spiMiso,
  input  logic              spiCsn,
  input  logic              cfgIdleHigh,
  input  logic              cfgShiftTrail,
  input  logic              cfgSampleLate,
  input  logic              hostValid,
  input  logic [7:0]        hostByte,
  input  logic              txReady,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              sniffActive
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  strobe_t          ctrlStrb;
  state_e           ctrlState;
  logic             csRise, csFall, csLevel, byteDone;
  logic [CNT_W-1:0] fifoFree;

  sniff_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hostValid(hostValid),
    .hostByte (hostByte),
    .csRise   (csRise),
    .csFall   (csFall),
    .csLevel  (csLevel),
    .byteDone (byteDone),
    .freeCnt  (fifoFree),
    .strb     (ctrlStrb),
    .state    (ctrlState)
  );

  sniff_data #(
    .DEPTH      (FIFO_DEPTH),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclkIn       (spiSclk),
    .mosiIn       (spiMosi),
    .misoIn       (spiMiso),
    .csnIn        (spiCsn),
    .cfgIdleHigh  (cfgIdleHigh),
    .cfgShiftTrail(cfgShiftTrail),
    .cfgSampleLate(cfgSampleLate),
    .strb         (ctrlStrb),
    .txReady      (txReady),
    .csRise       (csRise),
    .csFall       (csFall),
    .csLevel      (csLevel),
    .byteDone     (byteDone),
    .freeCnt      (fifoFree),
    .txValid      (txValid),
    .txData       (txData)
  );

  assign sniffActive = (ctrlState == ST_SNIFF);

endmodule

// File: rtl/spi_sniff_sva.sv
module spi_sniff_sva
  import spi_sniff_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hostValid,
  input logic [7:0]       hostByte,
  input logic             txValid,
  input logic             txReady,
  input logic [7:0]       txData,
  input logic             sniffActive,
  input state_e           state,
  input strobe_t          strb,
  input logic [CNT_W-1:0] freeCnt
);

  logic startCmd;
  assign startCmd = hostValid && (hostByte inside {CMD_ALL, CMD_LOW, CMD_HIGH});

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !startCmd) |=> !sniffActive);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && startCmd) |=> sniffActive);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sniffActive && hostValid && hostByte == CMD_RESTART) |=> sniffActive);

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sniffActive && hostValid && hostByte != CMD_RESTART) |=> !sniffActive);

  assert_push_fits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (3 * int'(strb.pushRecord) + int'(strb.pushOpen) + int'(strb.pushClose)
     + int'(strb.pushAck)) <= int'(freeCnt));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(freeCnt) <= DEPTH);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

endmodule

bind spi_sniff_enc spi_sniff_sva #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .hostValid  (hostValid),
  .hostByte   (hostByte),
  .txValid    (txValid),
  .txReady    (txReady),
  .txData     (txData),
  .sniffActive(sniffActive),
  .state      (ctrlState),
  .strb       (ctrlStrb),
  .freeCnt    (fifoFree)
);

// File: tb/spi_sniff_enc_tb.sv
module spi_sniff_enc_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spiSclk = 1'b0, spiMosi = 1'b0, spiMiso = 1'b0, spiCsn = 1'b1;
  logic cfgIdleHigh = 1'b0, cfgShiftTrail = 1'b1, cfgSampleLate = 1'b0;
  logic hostValid = 1'b0;
  logic [7:0] hostByte = 8'h00;
  logic txReady = 1'b1;
  logic txValid, sniffActive;
  logic [7:0] txData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit sampleLead = 1'b1;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  spi_sniff_enc u_dut (
    .clk(clk), .rst_n(rst_n),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsn(spiCsn),
    .cfgIdleHigh(cfgIdleHigh), .cfgShiftTrail(cfgShiftTrail), .cfgSampleLate(cfgSampleLate),
    .hostValid(hostValid), .hostByte(hostByte),
    .txReady(txReady), .txValid(txValid), .txData(txData), .sniffActive(sniffActive)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(string tag, logic [7:0] b);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic expect_rec(string tag, logic [7:0] m, logic [7:0] s);
    expect_byte(tag, 8'h5C);
    expect_byte(tag, m);
    expect_byte(tag, s);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && txValid && txReady) begin
      if (expQ.size() == 0) begin
        check("R11 unexpected stream byte", int'(txData), -1);
      end else begin
        check(tagQ.pop_front(), int'(txData), int'(expQ.pop_front()));
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_send(logic [7:0] b);
    @(negedge clk);
    hostValid = 1'b1;
    hostByte  = b;
    @(negedge clk);
    hostValid = 1'b0;
    cycles(3);
  endtask

  task automatic cs_set(logic v);
    @(negedge clk);
    spiCsn = v;
    cycles(6);
  endtask

  // data lines are wrong around the edge that must not be sampled
  task automatic spi_bits(logic [7:0] m, logic [7:0] s, int n);
    for (int i = 7; i > 7 - n; i--) begin
      if (sampleLead) begin
        spiMosi = m[i]; spiMiso = s[i];
      end else begin
        spiMosi = ~m[i]; spiMiso = ~s[i];
      end
      cycles(5);
      spiSclk = ~cfgIdleHigh;
      cycles(2);
      if (sampleLead) begin
        spiMosi = ~m[i]; spiMiso = ~s[i];
      end else begin
        spiMosi = m[i]; spiMiso = s[i];
      end
      cycles(3);
      spiSclk = cfgIdleHigh;
      cycles(2);
    end
    cycles(4);
  endtask

  task automatic spi_byte(logic [7:0] m, logic [7:0] s);
    spi_bits(m, s, 8);
  endtask

  task automatic drain(string tag);
    for (int t = 0; t < 3000; t++) begin
      if (expQ.size() == 0 && !txValid) break;
      @(negedge clk);
    end
    cycles(6);
    check({tag, " queue empty"}, expQ.size(), 0);
    check({tag, " txValid idle"}, int'(txValid), 0);
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
    // R1: reset state
    check("R1 reset txValid", int'(txValid), 0);
    check("R1 reset sniffActive", int'(sniffActive), 0);

    // R1: idle ignores bus and non-start host bytes
    cs_set(1'b0);
    spi_byte(8'hA5, 8'h3C);
    cs_set(1'b1);
    host_send(8'h41);
    check("R1 idle sniffActive", int'(sniffActive), 0);
    drain("R1 idle");

    // R2 R3 R4: csn-low mode, leading-edge sampling
    host_send(8'h0E);
    check("R2 low mode active", int'(sniffActive), 1);
    expect_byte("R3 open", 8'h5B);
    cs_set(1'b0);
    expect_rec("R4 record a", 8'hA5, 8'h3C);
    spi_byte(8'hA5, 8'h3C);
    expect_rec("R4 record b", 8'h01, 8'hFE);
    spi_byte(8'h01, 8'hFE);
    expect_byte("R3 close", 8'h5D);
    cs_set(1'b1);
    // R5: traffic at the other csn level is not captured
    spi_byte(8'h77, 8'h88);
    drain("R5 low mode gated");
    expect_byte("R9 ack", 8'h01);
    host_send(8'h20);
    check("R9 stopped", int'(sniffActive), 0);
    drain("R9 stop");

    // R2 R3 R5: csn-high mode
    host_send(8'h0F);
    check("R2 high mode active", int'(sniffActive), 1);
    expect_byte("R3 high-mode close on fall", 8'h5D);
    cs_set(1'b0);
    spi_byte(8'h77, 8'h88);
    expect_byte("R3 high-mode open on rise", 8'h5B);
    cs_set(1'b1);
    expect_rec("R5 high mode record", 8'hC3, 8'h5A);
    spi_byte(8'hC3, 8'h5A);
    expect_byte("R3 high-mode close", 8'h5D);
    cs_set(1'b0);
    expect_byte("R9 ack high", 8'h01);
    host_send(8'h00);
    drain("R5 high mode");
    cs_set(1'b1);

    // R6: idle-high clock, trailing-edge sampling, all-traffic mode
    cfgIdleHigh = 1'b1; cfgShiftTrail = 1'b0; cfgSampleLate = 1'b0;
    sampleLead = 1'b0;
    spiSclk = 1'b1;
    cycles(6);
    host_send(8'h0D);
    check("R2 all mode active", int'(sniffActive), 1);
    expect_rec("R5 all mode csn high", 8'h96, 8'h69);
    spi_byte(8'h96, 8'h69);
    expect_byte("R3 all open", 8'h5B);
    cs_set(1'b0);
    expect_rec("R6 trailing sample", 8'h12, 8'h34);
    spi_byte(8'h12, 8'h34);
    expect_byte("R3 all close", 8'h5D);
    cs_set(1'b1);
    // R6: late sample moves to leading edge
    cfgSampleLate = 1'b1;
    sampleLead = 1'b1;
    expect_rec("R6 late sample leading", 8'hF0, 8'h0F);
    spi_byte(8'hF0, 8'h0F);
    expect_byte("R9 ack all", 8'h01);
    host_send(8'h55);
    drain("R6 config");

    // R7: partial byte discarded on csn edge
    cfgIdleHigh = 1'b0; cfgShiftTrail = 1'b1; cfgSampleLate = 1'b0;
    sampleLead = 1'b1;
    spiSclk = 1'b0;
    cycles(6);
    host_send(8'h0E);
    expect_byte("R7 open", 8'h5B);
    cs_set(1'b0);
    spi_bits(8'hFF, 8'hFF, 4);
    expect_byte("R7 close no record", 8'h5D);
    cs_set(1'b1);
    expect_byte("R7 open again", 8'h5B);
    cs_set(1'b0);
    expect_rec("R7 clean byte", 8'h3A, 8'hC5);
    spi_byte(8'h3A, 8'hC5);
    expect_byte("R7 close", 8'h5D);
    cs_set(1'b1);
    drain("R7 partial");

    // R8: restart clears partial bits, stays active
    expect_byte("R8 open", 8'h5B);
    cs_set(1'b0);
    spi_bits(8'hFF, 8'h00, 3);
    host_send(8'h72);
    check("R8 still active", int'(sniffActive), 1);
    expect_rec("R8 record after restart", 8'h5E, 8'hE5);
    spi_byte(8'h5E, 8'hE5);
    expect_byte("R8 close", 8'h5D);
    cs_set(1'b1);
    expect_byte("R9 ack restart test", 8'h01);
    host_send(8'h33);
    drain("R8 restart");

    // R10: overflow with transmit stalled
    txReady = 1'b0;
    host_send(8'h0D);
    expect_byte("R10 open", 8'h5B);
    cs_set(1'b0);
    for (int k = 0; k < 10; k++) begin
      expect_rec("R10 fill", 8'(k + 8'h10), 8'(8'hE0 - k));
      spi_byte(8'(k + 8'h10), 8'(8'hE0 - k));
    end
    spi_byte(8'hAA, 8'hBB);
    cycles(4);
    check("R10 aborted status", int'(sniffActive), 0);
    cs_set(1'b1);
    check("R10 full holds txValid", int'(txValid), 1);
    txReady = 1'b1;
    drain("R10 drained, no partial record");
    host_send(8'h72);
    check("R10 resume", int'(sniffActive), 1);
    expect_byte("R10 ack after resume", 8'h01);
    host_send(8'h44);
    check("R10 stopped", int'(sniffActive), 0);
    drain("R10 end");

    finish_run();
  end

endmodule